// File: doc/BRIEF.md
# Slow-Attack Receive Gain Controller

This block steers the gain index of a receiver whose input level drifts slowly. Each average-power measurement arrives as a magnitude in negative dBFS, so a larger number means a weaker signal. The measurement is sorted into one of five zones: one hold band and two bands on each side of it. The inner band edges are programmed directly. Each outer edge is programmed as a dB offset from the inner edge next to it. The zone of the newest measurement sets a pending gain-index step. The four step sizes are programmed, and the hold band asks for no change.

The pending step does not reach the gain index at once. It waits until a gain update counter expires. The counter runs at the receive sample rate. It starts a fixed number of cycles after the receive state is entered. Its period is a programmed value times two or times four. An external sync input, when enabled, restarts it, so updates can be lined up with slot boundaries. At each expiry the latest pending step is applied, clamped to configured limits, and a one-cycle strobe is raised. The pending step is then cleared.

Top module: `slow_agc_ctrl`

## Requirements
- R1: While `rst_n` is low, `gain_idx` holds parameter RESET_GAIN (default 32) and `gain_upd` is 0.
- R2: With lim_hi = `thr_inner_hi` - `delta_hi` and lim_lo = `thr_inner_lo` + `delta_lo`, a magnitude m selects a zone as follows: m < lim_hi lowers the gain by `step_a`; lim_hi <= m < `thr_inner_hi` lowers it by `step_b`; `thr_inner_hi` <= m <= `thr_inner_lo` holds it; `thr_inner_lo` < m <= lim_lo raises it by `step_c`; m > lim_lo raises it by `step_d`.
- R3: lim_hi saturates at 0 and lim_lo saturates at the largest PWR_W-bit value. A value that would leave the range is clamped to the range end and does not wrap.
- R4: With `rx_active` first sampled high at rising edge 0, the first update (`gain_upd` high) follows edge START_DLY-1+T, where T is the update period. With the defaults this is edge T+2.
- R5: T is `upd_period`×2 when `upd_x4` is 0 and `upd_period`×4 when it is 1. Later updates follow every T edges.
- R6: At an update, only the latest measurement taken since the previous update sets the step. This includes a measurement sampled on the update edge itself. With no measurement in the period the gain holds, and the strobe still pulses.
- R7: The pending step is cleared at each update. A period with no new measurement therefore leaves the gain unchanged.
- R8: An edge at which `rx_active`, `sync_en` and `sync_in` are all high resets the counter, and the next update follows T edges later. `sync_in` has no effect while `sync_en` is 0.
- R9: An edge with `rx_active` low clears the counter and discards any pending step. No strobe occurs and the gain does not change while `rx_active` is low. Re-entry restarts the delay of R4.
- R10: A decrease never goes below `gain_min`, and an increase never goes above `gain_max`.
- R11: A measurement presented while `rx_active` is low is ignored.
- R12: `gain_upd` is high for exactly one cycle per update. `gain_idx` changes only on a cycle where `gain_upd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive sample-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | Receiver is in the receive state |
| sync_en | input | 1 | Allows `sync_in` to restart the update counter |
| sync_in | input | 1 | External counter restart |
| pwr_valid | input | 1 | New power measurement present |
| pwr_mag | input | PWR_W | Average power, negative dBFS magnitude |
| thr_inner_hi | input | PWR_W | Strong-side edge of the hold band |
| thr_inner_lo | input | PWR_W | Weak-side edge of the hold band |
| delta_hi | input | PWR_W | Offset from the strong inner edge to the strong outer edge |
| delta_lo | input | PWR_W | Offset from the weak inner edge to the weak outer edge |
| step_a | input | STEP_W | Decrease size, strongest zone |
| step_b | input | STEP_W | Decrease size, moderate zone |
| step_c | input | STEP_W | Increase size, moderate zone |
| step_d | input | STEP_W | Increase size, weakest zone |
| upd_period | input | CNT_W | Update period base value |
| upd_x4 | input | 1 | Period multiplier select: 0 for ×2, 1 for ×4 |
| gain_min | input | GAIN_W | Lowest allowed gain index |
| gain_max | input | GAIN_W | Highest allowed gain index |
| gain_idx | output | GAIN_W | Current gain index |
| gain_upd | output | 1 | One-cycle update strobe |

## Verification
The bench probes every zone edge with equality values. A design with an off-by-one comparison would step the gain by the wrong amount, or in the wrong direction, at exactly those magnitudes. It counts edges from receive entry and from a sync pulse. A wrong start delay, a wrong period multiplier or a sync that fails to restart the counter would move the strobe by a cycle or more. It sends two measurements in one period, the second one on the update edge itself, so a design that kept the first measurement or missed the last one applies the wrong step. It also drives the offsets and steps to extremes: outer limits that wrap, or gain arithmetic that wraps instead of clamping, give a wrong zone or a wrong index.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic [2:0] {
        Z_HOLD  = 3'd0,
        Z_DEC_A = 3'd1,
        Z_DEC_B = 3'd2,
        Z_INC_C = 3'd3,
        Z_INC_D = 3'd4
    } zone_e;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_DLY  = 2'd1,
        T_RUN  = 2'd2
    } tmr_st_e;
endpackage

// File: rtl/agc_zone_sel.sv
module agc_zone_sel
    import agc_pkg::*;
#(
    parameter int PWR_W = 8
) (
    input  logic [PWR_W-1:0] pwr_mag,
    input  logic [PWR_W-1:0] thr_inner_hi,
    input  logic [PWR_W-1:0] thr_inner_lo,
    input  logic [PWR_W-1:0] delta_hi,
    input  logic [PWR_W-1:0] delta_lo,
    output zone_e            zone
);
    localparam int WW = PWR_W + 1;

    logic [PWR_W-1:0] lim_hi;
    logic [PWR_W-1:0] lim_lo;
    logic [WW-1:0]    lo_sum;

    // Outer limits derived from the inner ones, saturating (R3)
    always_comb begin
        lim_hi = (delta_hi > thr_inner_hi) ? '0 : thr_inner_hi - delta_hi;
        lo_sum = WW'(thr_inner_lo) + WW'(delta_lo);
        lim_lo = lo_sum[PWR_W] ? '1 : lo_sum[PWR_W-1:0];
    end

    // Five-zone classification (R2)
    always_comb begin
        if (pwr_mag < lim_hi)            zone = Z_DEC_A;
        else if (pwr_mag < thr_inner_hi) zone = Z_DEC_B;
        else if (pwr_mag <= thr_inner_lo) zone = Z_HOLD;
        else if (pwr_mag <= lim_lo)      zone = Z_INC_C;
        else                             zone = Z_INC_D;
    end
endmodule

// File: rtl/agc_update_timer.sv
module agc_update_timer
    import agc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int START_DLY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_active,
    input  logic             sync_en,
    input  logic             sync_in,
    input  logic [CNT_W-1:0] upd_period,
    input  logic             upd_x4,
    output logic             expire
);
    localparam int CW    = CNT_W + 2;
    localparam int DLY_W = $clog2(START_DLY + 1) + 1;

    typedef struct packed {
        tmr_st_e          st;
        logic [DLY_W-1:0] dly;
        logic [CW-1:0]    cnt;
    } tmr_t;

    tmr_t          tmr_d, tmr_q;
    logic [CW-1:0] term;
    logic [CW-1:0] term_m1;

    always_comb begin
        term    = upd_x4 ? {upd_period, 2'b00} : {1'b0, upd_period, 1'b0};
        term_m1 = (term == '0) ? '0 : term - 1'b1;
    end

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (!rx_active) begin
            tmr_d.st  = T_IDLE;
            tmr_d.dly = '0;
            tmr_d.cnt = '0;
        end else begin
            case (tmr_q.st)
                T_IDLE: begin
                    tmr_d.cnt = '0;
                    if (START_DLY <= 1) begin
                        tmr_d.st = T_RUN;
                    end else begin
                        tmr_d.st  = T_DLY;
                        tmr_d.dly = DLY_W'(1);
                    end
                end
                T_DLY: begin
                    if (tmr_q.dly >= DLY_W'(START_DLY - 1)) begin
                        tmr_d.st  = T_RUN;
                        tmr_d.cnt = '0;
                    end else begin
                        tmr_d.dly = tmr_q.dly + 1'b1;
                    end
                end
                T_RUN: begin
                    if (sync_en && sync_in) begin
                        tmr_d.cnt = '0;
                    end else if (tmr_q.cnt >= term_m1) begin
                        tmr_d.cnt = '0;
                        expire    = 1'b1;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + 1'b1;
                    end
                end
                default: tmr_d.st = T_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.st  <= T_IDLE;
            tmr_q.dly <= '0;
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R8: a sync edge in run leaves the counter at zero
    a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.st == T_RUN && rx_active && sync_en && sync_in)
        |=> (tmr_q.cnt == '0 && tmr_q.st == T_RUN));

    // R4: the delay ends in the run state with a fresh count
    a_r4_start_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.st == T_DLY && rx_active && tmr_q.dly >= DLY_W'(START_DLY - 1))
        |=> (tmr_q.st == T_RUN && tmr_q.cnt == '0));

    // R9: leaving receive returns the counter to idle
    a_r9_idle_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |=> (tmr_q.st == T_IDLE && tmr_q.cnt == '0));
endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step
    import agc_pkg::*;
#(
    parameter int GAIN_W     = 7,
    parameter int STEP_W     = 5,
    parameter int RESET_GAIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  zone_e             zone,
    input  logic [STEP_W-1:0] step_a,
    input  logic [STEP_W-1:0] step_b,
    input  logic [STEP_W-1:0] step_c,
    input  logic [STEP_W-1:0] step_d,
    input  logic [GAIN_W-1:0] gain_min,
    input  logic [GAIN_W-1:0] gain_max,
    output logic [GAIN_W-1:0] gain_idx,
    output logic              gain_upd
);
    localparam int EW = ((GAIN_W > STEP_W) ? GAIN_W : STEP_W) + 1;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              upd;
    } gst_t;

    gst_t              g_d, g_q;
    logic [STEP_W-1:0] step_sel;
    logic [EW-1:0]     g_w;
    logic [EW-1:0]     s_w;
    logic [EW-1:0]     sum_w;

    always_comb begin
        case (zone)
            Z_DEC_A: step_sel = step_a;
            Z_DEC_B: step_sel = step_b;
            Z_INC_C: step_sel = step_c;
            Z_INC_D: step_sel = step_d;
            default: step_sel = '0;
        endcase
        g_w   = EW'(g_q.gain);
        s_w   = EW'(step_sel);
        sum_w = g_w + s_w;
    end

    always_comb begin
        g_d     = g_q;
        g_d.upd = apply;
        if (apply) begin
            case (zone)
                Z_DEC_A, Z_DEC_B: begin
                    if (g_w < EW'(gain_min) + s_w) g_d.gain = gain_min;
                    else                           g_d.gain = GAIN_W'(g_w - s_w);
                end
                Z_INC_C, Z_INC_D: begin
                    if (sum_w > EW'(gain_max)) g_d.gain = gain_max;
                    else                       g_d.gain = GAIN_W'(sum_w);
                end
                default: g_d.gain = g_q.gain;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.gain <= GAIN_W'(RESET_GAIN);
            g_q.upd  <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign gain_idx = g_q.gain;
    assign gain_upd = g_q.upd;

    // R10: a moving update lands inside the configured range
    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && zone != Z_HOLD && gain_min <= gain_max)
        |=> (gain_idx >= $past(gain_min) && gain_idx <= $past(gain_max)));

    // R12: the index only moves alongside the strobe
    a_r12_move_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_upd |-> $stable(gain_idx));

    // R12: the strobe follows a timer expiry
    a_r12_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd |-> $past(apply));
endmodule

// File: rtl/slow_agc_ctrl.sv
module slow_agc_ctrl
    import agc_pkg::*;
#(
    parameter int PWR_W      = 8,
    parameter int STEP_W     = 5,
    parameter int GAIN_W     = 7,
    parameter int CNT_W      = 16,
    parameter int START_DLY  = 3,
    parameter int RESET_GAIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_active,
    input  logic              sync_en,
    input  logic              sync_in,
    input  logic              pwr_valid,
    input  logic [PWR_W-1:0]  pwr_mag,
    input  logic [PWR_W-1:0]  thr_inner_hi,
    input  logic [PWR_W-1:0]  thr_inner_lo,
    input  logic [PWR_W-1:0]  delta_hi,
    input  logic [PWR_W-1:0]  delta_lo,
    input  logic [STEP_W-1:0] step_a,
    input  logic [STEP_W-1:0] step_b,
    input  logic [STEP_W-1:0] step_c,
    input  logic [STEP_W-1:0] step_d,
    input  logic [CNT_W-1:0]  upd_period,
    input  logic              upd_x4,
    input  logic [GAIN_W-1:0] gain_min,
    input  logic [GAIN_W-1:0] gain_max,
    output logic [GAIN_W-1:0] gain_idx,
    output logic              gain_upd
);
    typedef struct packed {
        zone_e zone;
    } pend_t;

    pend_t pend_d, pend_q;
    zone_e zone_now;
    zone_e zone_eff;
    logic  expire;

    agc_zone_sel #(.PWR_W(PWR_W)) i_zone (
        .pwr_mag      (pwr_mag),
        .thr_inner_hi (thr_inner_hi),
        .thr_inner_lo (thr_inner_lo),
        .delta_hi     (delta_hi),
        .delta_lo     (delta_lo),
        .zone         (zone_now)
    );

    agc_update_timer #(.CNT_W(CNT_W), .START_DLY(START_DLY)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_active  (rx_active),
        .sync_en    (sync_en),
        .sync_in    (sync_in),
        .upd_period (upd_period),
        .upd_x4     (upd_x4),
        .expire     (expire)
    );

    // Newest measurement wins, including one on the expiry edge (R6)
    always_comb begin
        zone_eff = (rx_active && pwr_valid) ? zone_now : pend_q.zone;
        pend_d   = pend_q;
        if (!rx_active || expire) pend_d.zone = Z_HOLD;
        else if (pwr_valid)       pend_d.zone = zone_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q.zone <= Z_HOLD;
        else        pend_q      <= pend_d;
    end

    agc_gain_step #(
        .GAIN_W     (GAIN_W),
        .STEP_W     (STEP_W),
        .RESET_GAIN (RESET_GAIN)
    ) i_gain (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (expire),
        .zone     (zone_eff),
        .step_a   (step_a),
        .step_b   (step_b),
        .step_c   (step_c),
        .step_d   (step_d),
        .gain_min (gain_min),
        .gain_max (gain_max),
        .gain_idx (gain_idx),
        .gain_upd (gain_upd)
    );

    // R9: no update is issued for an edge outside receive
    a_r9_quiet_outside_rx: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |=> !gain_upd);

    // R7: nothing stays pending across an update
    a_r7_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd |-> (pend_q.zone == Z_HOLD || $past(pwr_valid) == 1'b0));
endmodule

// File: tb/test_slow_agc_ctrl.sv
module test_slow_agc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int GMIN = 10;
    localparam int GMAX = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_active = 1'b0;
    logic        sync_en = 1'b0;
    logic        sync_in = 1'b0;
    logic        pwr_valid = 1'b0;
    logic [7:0]  pwr_mag = '0;
    logic [7:0]  thr_inner_hi = 8'd20;
    logic [7:0]  thr_inner_lo = 8'd30;
    logic [7:0]  delta_hi = 8'd5;
    logic [7:0]  delta_lo = 8'd6;
    logic [4:0]  step_a = 5'd8;
    logic [4:0]  step_b = 5'd3;
    logic [4:0]  step_c = 5'd2;
    logic [4:0]  step_d = 5'd6;
    logic [15:0] upd_period = 16'd3;
    logic        upd_x4 = 1'b0;
    logic [6:0]  gain_min = 7'(GMIN);
    logic [6:0]  gain_max = 7'(GMAX);
    logic [6:0]  gain_idx;
    logic        gain_upd;

    int checks = 0;
    int errors = 0;
    int exp_gain = 32;

    always #(CLK_PERIOD/2) clk = ~clk;

    slow_agc_ctrl i_slow_agc_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .sync_en(sync_en),
        .sync_in(sync_in), .pwr_valid(pwr_valid), .pwr_mag(pwr_mag),
        .thr_inner_hi(thr_inner_hi), .thr_inner_lo(thr_inner_lo),
        .delta_hi(delta_hi), .delta_lo(delta_lo), .step_a(step_a),
        .step_b(step_b), .step_c(step_c), .step_d(step_d),
        .upd_period(upd_period), .upd_x4(upd_x4), .gain_min(gain_min),
        .gain_max(gain_max), .gain_idx(gain_idx), .gain_upd(gain_upd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int dec(input int g, input int s);
        return (g - s < GMIN) ? GMIN : g - s;
    endfunction

    function automatic int inc(input int g, input int s);
        return (g + s > GMAX) ? GMAX : g + s;
    endfunction

    // Present one measurement for one edge; starts and ends at a negedge
    task automatic measure(input int m);
        pwr_valid = 1'b1;
        pwr_mag   = 8'(m);
        @(negedge clk);
        pwr_valid = 1'b0;
    endtask

    task automatic wait_strobe(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!gain_upd && n < 200);
        chk(tag, int'(gain_upd), 1);
    endtask

    task automatic rx_off();
        rx_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset gain", int'(gain_idx), 32);
        chk("R1 reset strobe", int'(gain_upd), 0);
    endtask

    task automatic t_timing();
        upd_period = 16'd3; upd_x4 = 1'b0;
        rx_active = 1'b1;
        for (int k = 0; k <= 8; k++) begin
            @(negedge clk);
            chk($sformatf("R4 start edge %0d", k), int'(gain_upd), int'(k == 8));
        end
        chk("R6 no measurement holds", int'(gain_idx), exp_gain);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk($sformatf("R5 x2 edge %0d", k), int'(gain_upd), int'(k == 6));
        end
        rx_off();
        upd_x4 = 1'b1;
        rx_active = 1'b1;
        for (int k = 0; k <= 14; k++) begin
            @(negedge clk);
            chk($sformatf("R5 x4 edge %0d", k), int'(gain_upd), int'(k == 14));
        end
        rx_off();
        upd_x4 = 1'b0;
        rx_active = 1'b1;
        wait_strobe("R4 re-entry");
    endtask

    task automatic zone_case(input int m, input int kind, input string tag);
        measure(m);
        case (kind)
            1: exp_gain = dec(exp_gain, int'(step_a));
            2: exp_gain = dec(exp_gain, int'(step_b));
            3: exp_gain = inc(exp_gain, int'(step_c));
            4: exp_gain = inc(exp_gain, int'(step_d));
            default: ;
        endcase
        wait_strobe(tag);
        chk(tag, int'(gain_idx), exp_gain);
    endtask

    task automatic t_zones();
        zone_case(10, 1, "R2 far strong");
        zone_case(15, 2, "R2 at strong outer edge");
        zone_case(20, 0, "R2 at strong inner edge");
        zone_case(30, 0, "R2 at weak inner edge");
        zone_case(31, 3, "R2 just past weak inner");
        zone_case(36, 3, "R2 at weak outer edge");
        zone_case(37, 4, "R2 far weak");
        zone_case(19, 2, "R2 just inside strong band");
    endtask

    task automatic t_latest();
        measure(10);
        measure(37);
        exp_gain = inc(exp_gain, int'(step_d));
        wait_strobe("R6 latest");
        chk("R6 second measurement wins", int'(gain_idx), exp_gain);
        measure(10);
        repeat (4) @(negedge clk);
        pwr_valid = 1'b1; pwr_mag = 8'd37;
        @(negedge clk);
        pwr_valid = 1'b0;
        exp_gain = inc(exp_gain, int'(step_d));
        chk("R6 strobe on edge", int'(gain_upd), 1);
        chk("R6 measurement on update edge", int'(gain_idx), exp_gain);
        wait_strobe("R7 next period");
        chk("R7 pending cleared", int'(gain_idx), exp_gain);
    endtask

    task automatic t_sync();
        repeat (2) @(negedge clk);
        sync_en = 1'b1; sync_in = 1'b1;
        @(negedge clk);
        sync_en = 1'b0; sync_in = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk($sformatf("R8 after sync %0d", k), int'(gain_upd), int'(k == 6));
        end
        repeat (2) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        for (int k = 4; k <= 6; k++) begin
            @(negedge clk);
            chk($sformatf("R8 disabled sync %0d", k), int'(gain_upd), int'(k == 6));
        end
    endtask

    task automatic t_rx_leave();
        int seen = 0;
        measure(10);
        rx_active = 1'b0;
        pwr_valid = 1'b1; pwr_mag = 8'd37;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (gain_upd) seen++;
        end
        pwr_valid = 1'b0;
        chk("R9 no strobe outside rx", seen, 0);
        chk("R9 gain held outside rx", int'(gain_idx), exp_gain);
        rx_active = 1'b1;
        for (int k = 0; k <= 8; k++) begin
            @(negedge clk);
            chk($sformatf("R9 restart edge %0d", k), int'(gain_upd), int'(k == 8));
        end
        chk("R9 R11 pending discarded", int'(gain_idx), exp_gain);
    endtask

    task automatic t_saturate();
        step_a = 5'd31; step_d = 5'd31;
        zone_case(0, 1, "R10 floor");
        zone_case(0, 1, "R10 stay at floor");
        zone_case(200, 4, "R10 rise");
        zone_case(200, 4, "R10 ceiling");
        step_a = 5'd8; step_d = 5'd6;
        thr_inner_hi = 8'd3; delta_hi = 8'd10;
        zone_case(0, 2, "R3 strong outer clamps at zero");
        thr_inner_lo = 8'd250; delta_lo = 8'd20;
        zone_case(255, 3, "R3 weak outer clamps at top");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_timing();
        t_zones();
        t_latest();
        t_sync();
        t_rx_leave();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule